// File: doc/BRIEF.md
# Random Replacement Index Generator for a Translation Buffer

The block picks the slot a translation buffer should overwrite when software asks for a random-replacement write. A 32-bit pseudo-random sequence is stepped on each request. Its value is reduced into the replaceable window of slots, which starts at the locked (wired) boundary and ends at the last slot. The block never hands out the same slot twice in a row. If a reduced value repeats the slot it returned last, the sequence is stepped again and the value is reduced once more.

The reduction uses a sequential restoring divider that yields one quotient bit per cycle, so a request takes a whole number of 33-cycle attempts. Each accepted request ends with a single-cycle valid pulse that carries the index. The slot count and the locked count can change at run time. They are captured when a request is accepted.

Top module: `tlb_rand_idx`

## Requirements
- R1: After reset, valid_o and busy_o are 0, the sequence state is 1 and the remembered previous index is 0. The first request therefore works from the state reached by one step from 1.
- R2: One step of the sequence shifts the 32-bit state right by one bit. When the bit shifted out was 1, the shifted value is XORed with 0xD0000001. The state never becomes zero.
- R3: A candidate index is (state mod (entries − wired)) + wired. Every returned index lies in [wired, entries−1].
- R4: When the candidate equals the previously returned index, the sequence steps again and a new candidate is formed. A returned index differs from the previous one whenever the window holds more than one slot.
- R5: Each returned index becomes the previous index for the next request.
- R6: A request accepted at clock edge E0 returns its index at edge E0 + 33·A, where A is the number of candidates formed. valid_o is high for exactly one cycle.
- R7: busy_o is 1 from the accept edge until the result edge, and valid_o is 0 throughout. A request that arrives while busy_o is 1 is ignored. It causes no extra step, no change of timing and no extra result.
- R8: When the window holds exactly one slot, that slot is returned after one attempt, even if it equals the previous index.
- R9: entries_i and wired_i are captured at the accept edge. Changes to them during a computation do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, accepted when not busy |
| entries_i | input | 7 | Total slot count (must exceed wired_i) |
| wired_i | input | 7 | Number of locked slots at the bottom |
| idx_o | output | 7 | Returned replacement index, meaningful when valid_o is 1 |
| valid_o | output | 1 | One-cycle pulse marking a returned index |
| busy_o | output | 1 | Computation in progress |

## Verification
The bench uses two-slot windows to force repeated candidates. A design that skipped the retry would hand back the previous slot, and one that retried wrongly would be off by whole 33-cycle attempts. One-slot windows are requested back to back, where a design that looped on a repeated candidate would hang and a design that rejected the repeat would stall. Mid-computation requests and changes to the slot counts check that nothing leaks into an operation in flight: a design that re-sampled its inputs or accepted the second strobe would return a different index or raise an extra pulse. The very first result after reset is checked against the sequence started from seed 1.

// File: rtl/tlb_rand_pkg.sv
package tlb_rand_pkg;

    localparam int unsigned LFSR_W    = 32;
    localparam logic [LFSR_W-1:0] LFSR_TAP  = 32'hD000_0001;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 32'h0000_0001;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ctl_state_e;

    // One right-shifting Galois step of the pseudo-random sequence
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] cur);
        logic [LFSR_W-1:0] sh;
        sh = cur >> 1;
        if (cur[0]) begin
            sh = sh ^ LFSR_TAP;
        end
        return sh;
    endfunction

endpackage

// File: rtl/lfsr_gen.sv
module lfsr_gen
    import tlb_rand_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    output logic [LFSR_W-1:0] next_o
);

    logic [LFSR_W-1:0] state_q;

    assign next_o = lfsr_next(state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LFSR_SEED;
        end else if (step_i) begin
            state_q <= next_o;
        end
    end

    // A zero state would lock the sequence forever
    assert_state_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: rtl/mod_seq.sv
module mod_seq #(
    parameter int unsigned DVD_W = 32,
    parameter int unsigned DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             done_o,
    output logic [DIV_W-1:0] rem_o
);

    localparam int unsigned CNT_W = $clog2(DVD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

    logic [DVD_W-1:0] dvd_q;
    logic [DIV_W-1:0] dsr_q;
    logic [DIV_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             done_q;

    logic [DIV_W:0] trial;
    logic [DIV_W:0] diff;
    logic [DIV_W-1:0] rem_nx;

    always_comb begin
        trial  = {rem_q, dvd_q[DVD_W-1]};
        diff   = trial - {1'b0, dsr_q};
        rem_nx = (trial >= {1'b0, dsr_q}) ? diff[DIV_W-1:0] : trial[DIV_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q  <= '0;
            dsr_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                dvd_q <= dividend_i;
                dsr_q <= divisor_i;
                rem_q <= '0;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_nx;
                dvd_q <= dvd_q << 1;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign rem_o  = rem_q;

    // Remainder must fall below the divisor once reduction finishes
    assert_rem_below_R3: assert property (@(posedge clk) disable iff (rst)
        (done_q && dsr_q != '0) |-> (rem_q < dsr_q));

    // Done never coincides with an iteration still in flight
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !run_q);

endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx
    import tlb_rand_pkg::*;
#(
    parameter int unsigned IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic [IDX_W-1:0] entries_i,
    input  logic [IDX_W-1:0] wired_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o,
    output logic             busy_o
);

    localparam logic [IDX_W-1:0] ONE_SLOT = IDX_W'(1);

    typedef struct packed {
        logic [IDX_W-1:0] wired;
        logic [IDX_W-1:0] span;
    } win_t;

    ctl_state_e        state_q;
    win_t              win_q;
    logic [IDX_W-1:0]  prev_q;
    logic [IDX_W-1:0]  idx_q;
    logic              valid_q;

    logic              accept;
    logic              retry;
    logic              finish;
    logic              kick;
    logic [IDX_W-1:0]  span_in;
    logic [IDX_W-1:0]  start_dsr;
    logic [IDX_W-1:0]  cand;
    logic [LFSR_W-1:0] lfsr_nx;
    logic              div_done;
    logic [IDX_W-1:0]  div_rem;

    assign span_in   = entries_i - wired_i;
    assign accept    = req_i && (state_q == ST_IDLE);
    assign cand      = div_rem + win_q.wired;
    assign retry     = (state_q == ST_WAIT) && div_done &&
                       (cand == prev_q) && (win_q.span != ONE_SLOT);
    assign finish    = (state_q == ST_WAIT) && div_done && !retry;
    assign kick      = accept || retry;
    assign start_dsr = accept ? span_in : win_q.span;

    lfsr_gen i_lfsr (
        .clk    (clk),
        .rst    (rst),
        .step_i (kick),
        .next_o (lfsr_nx)
    );

    mod_seq #(
        .DVD_W (LFSR_W),
        .DIV_W (IDX_W)
    ) i_mod (
        .clk        (clk),
        .rst        (rst),
        .start_i    (kick),
        .dividend_i (lfsr_nx),
        .divisor_i  (start_dsr),
        .done_o     (div_done),
        .rem_o      (div_rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            win_q   <= '0;
            prev_q  <= '0;
            idx_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (accept) begin
                win_q.wired <= wired_i;
                win_q.span  <= span_in;
                state_q     <= ST_WAIT;
            end else if (finish) begin
                idx_q   <= cand;
                prev_q  <= cand;
                valid_q <= 1'b1;
                state_q <= ST_IDLE;
            end
        end
    end

    assign idx_o   = idx_q;
    assign valid_o = valid_q;
    assign busy_o  = (state_q == ST_WAIT);

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    assert_in_window_R3: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (idx_q >= win_q.wired) && (idx_q < win_q.wired + win_q.span));

    assert_no_repeat_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_q && win_q.span != ONE_SLOT) |-> (idx_q != $past(prev_q)));

    assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !valid_q);

    assert_window_held_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(win_q));

endmodule

// File: tb/test_tlb_rand_idx.sv
`timescale 1ns/1ps
module test_tlb_rand_idx;

    localparam int IDX_W = 7;
    localparam int ATTEMPT = 33;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_i = 1'b0;
    logic [IDX_W-1:0] entries_i = '0;
    logic [IDX_W-1:0] wired_i = '0;
    logic [IDX_W-1:0] idx_o;
    logic             valid_o;
    logic             busy_o;

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural reference state
    logic [31:0] m_lfsr = 32'd1;
    int          m_prev = 0;

    always #2 clk = ~clk;

    tlb_rand_idx #(.IDX_W(IDX_W)) i_tlb_rand_idx (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .entries_i (entries_i),
        .wired_i   (wired_i),
        .idx_o     (idx_o),
        .valid_o   (valid_o),
        .busy_o    (busy_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_step(input logic [31:0] s);
        logic [31:0] r;
        r = s >> 1;
        if (s[0]) r = r ^ 32'hD0000001;
        return r;
    endfunction

    // One request; dis=1 pulses a stray request and changes counts mid-flight
    task automatic do_req(input int n, input int w, input bit dis, input string tag);
        int attempts = 0;
        int cand;
        int span = n - w;
        int lat;
        forever begin
            m_lfsr = ref_step(m_lfsr);
            attempts++;
            cand = int'(m_lfsr % 32'(span)) + w;
            if (cand != m_prev || span == 1) break;
        end
        lat = ATTEMPT * attempts;
        @(negedge clk);
        req_i = 1'b1; entries_i = IDX_W'(n); wired_i = IDX_W'(w);
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0;
        check(busy_o == 1'b1 && valid_o == 1'b0, {tag, " R7 busy after accept"},
              int'(busy_o), 1);
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (dis && k == 5) begin
                req_i = 1'b1; entries_i = 7'd100; wired_i = 7'd3;
            end
            if (dis && k == 6) req_i = 1'b0;
            if (k < lat) begin
                check(valid_o == 1'b0 && busy_o == 1'b1, {tag, " R6 R7 no early result"},
                      int'(valid_o), 0);
            end else begin
                check(valid_o == 1'b1 && busy_o == 1'b0, {tag, " R6 result timing"},
                      int'(valid_o), 1);
                check(int'(idx_o) == cand, {tag, " R3 R4 R5 index"}, int'(idx_o), cand);
                check(int'(idx_o) >= w && int'(idx_o) < n, {tag, " R3 window"},
                      int'(idx_o), w);
            end
        end
        m_prev = cand;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(valid_o == 1'b0, "R1 reset valid", int'(valid_o), 0);
        check(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
        // first result from seed 1 with previous index 0
        do_req(48, 0, 1'b0, "R1 R2 first");
        for (int i = 0; i < 6; i++) do_req(48, 0, 1'b0, "R2 full window");
        for (int i = 0; i < 6; i++) do_req(48, 8, 1'b0, "R3 wired window");
        for (int i = 0; i < 8; i++) do_req(10, 8, 1'b0, "R4 two slot");
        do_req(16, 15, 1'b0, "R8 single a");
        do_req(16, 15, 1'b0, "R8 single b");
        do_req(16, 15, 1'b0, "R8 single c");
        for (int i = 0; i < 4; i++) do_req(40, 5, 1'b1, "R7 R9 disturbed");
        do_req(127, 0, 1'b0, "R5 after disturb");
        for (int i = 0; i < 4; i++) do_req(12, 10, 1'b1, "R9 R4 disturbed two");
        @(negedge clk);
        check(valid_o == 1'b0 && busy_o == 1'b0, "R7 no stray result", int'(valid_o), 0);
        repeat (40) @(negedge clk);
        check(valid_o == 1'b0 && busy_o == 1'b0, "R7 idle stays idle", int'(busy_o), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R6 actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule